// File: doc/BRIEF.md
# SDRAM Byte-Mask Data Path

This block sits on the device side of a 16-bit, two-bank synchronous DRAM, between the pins and the storage array. It takes two per-byte mask inputs and applies them to the two directions of data flow. During a write the mask acts at once: each mask bit decides, in the same cycle, whether its byte of incoming data is strobed into the array. During a read the mask acts with a two-cycle delay: the bits sampled on one cycle decide which bytes are driven on the cycle two clocks later. A byte that is not driven is shown by a low per-byte output enable, which stands for high impedance.

The block also tracks whether an access is in progress. A write access ends two cycles after its last data-in cycle, and a read access ends one cycle after its last data-out cycle. A power-down or hold request on the cycle right after the last write data-in cycle is illegal, and the block reports it with a one-cycle flag. While the clock enable is low, the read mask pipeline and the access-end counters keep their values.

Top module: `sdram_bytemask_dp`

## Requirements
- R1: Mask bit 0 governs data bits 7:0 and mask bit 1 governs data bits 15:8, each on its own lane with no effect on the other.
- R2: A cycle is a write cycle when clkEn is high and either bank's state code is 2'b10. In a write cycle arrWrStrobe[i] equals the inverse of maskIn[i] in that same cycle, and arrWrData carries wrDataIn with each unstrobed byte forced to zero. Outside write cycles arrWrStrobe is zero.
- R3: A cycle is a read cycle when clkEn is high and either bank's state code is 2'b11. The mask sampled in a read cycle sets rdOutEn two clock-enabled cycles later: a low bit enables the byte and rdDataOut shows that byte of arrRdData, while a high bit disables it and rdDataOut shows zero for it.
- R4: When no bank has the read code (idle 2'b00, activated 2'b01 or write 2'b10) in a clock-enabled cycle, both output enables are low two clock-enabled cycles later, whatever maskIn was.
- R5: While clkEn is low no write strobe is raised, and the read mask pipeline (hence rdOutEn) and the access-end counters hold their values.
- R6: accessBusy is high while either bank has the write or read code, for one further clock-enabled cycle after the last write cycle, and for two further clock-enabled cycles after the last read cycle.
- R7: When sleepReq or holdReq is high in the cycle right after a write cycle, and that cycle is not itself a write cycle, protoViol is high for exactly the next cycle.
- R8: After reset the output enables, protoViol and both access-end counters are cleared, so with idle banks accessBusy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clkEn | input | 1 | Clock enable; low suspends the mask pipeline and counters |
| bankState | input | 4 | Two bits per bank, bank 0 in bits 1:0: 00 idle, 01 activated, 10 write, 11 read |
| maskIn | input | 2 | Per-byte mask, bit 0 for bits 7:0, bit 1 for bits 15:8 |
| sleepReq | input | 1 | Power-down entry request |
| holdReq | input | 1 | Hold request |
| wrDataIn | input | 16 | Incoming write data |
| arrRdData | input | 16 | Data read from the array |
| arrWrStrobe | output | 2 | Per-byte array write strobes |
| arrWrData | output | 16 | Write data with unstrobed bytes zeroed |
| rdDataOut | output | 16 | Read data with disabled bytes zeroed |
| rdOutEn | output | 2 | Per-byte output enables; low means high impedance |
| accessBusy | output | 1 | Access operation in progress |
| protoViol | output | 1 | One-cycle protocol-violation flag |

## Verification
The properties take every 2-bit bank code as legal, including both banks carrying access codes at once, and assume clkEn and the mask are known at each rising edge; the read-latency property only claims a result when clkEn is also high on the cycle between sampling and output, because a suspend in between shifts the result. The stimulus changes inputs only at the falling clock edge, holds reset across the first edges, sweeps every combination of bank codes, mask and clock enable, and adds directed runs where a suspend falls inside a read pipeline and where a request follows the last write.

// File: rtl/sdram_bytemask_pkg.sv
package sdram_bytemask_pkg;

  // Per-bank access state code
  typedef enum logic [1:0] {
    BANK_IDLE   = 2'b00,
    BANK_ACTIVE = 2'b01,
    BANK_WRITE  = 2'b10,
    BANK_READ   = 2'b11
  } bankCode_e;

  // Strobes from control to the byte lanes
  typedef struct packed {
    logic advance;   // clock enabled this cycle
    logic wrCycle;   // write data accepted this cycle
    logic rdCycle;   // read mask sampled this cycle
  } laneCtrl_t;

endpackage

// File: rtl/sdram_bytemask_tail.sv
// Access-end counter: loads TAIL on an access cycle, counts down on
// enabled cycles, holds while the clock is suspended.
module sdram_bytemask_tail #(
  parameter int TAIL = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  input  logic load,
  output logic active
);
  localparam int CW = (TAIL < 1) ? 1 : $clog2(TAIL + 1);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (advance) begin
      if (load)
        count <= CW'(TAIL);
      else if (count != '0)
        count <= count - CW'(1);
    end
  end

  assign active = (count != '0);
endmodule

// File: rtl/sdram_bytemask_ctrl.sv
module sdram_bytemask_ctrl
  import sdram_bytemask_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int WR_TAIL   = 1,
  parameter int RD_TAIL   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clkEn,
  input  logic [2*NUM_BANKS-1:0] bankState,
  input  logic                   sleepReq,
  input  logic                   holdReq,
  output laneCtrl_t              laneCtrl,
  output logic                   accessBusy,
  output logic                   protoViol
);
  logic [NUM_BANKS-1:0] bankWr;
  logic [NUM_BANKS-1:0] bankRd;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign bankWr[i] = (bankState[2*i +: 2] == BANK_WRITE);
    assign bankRd[i] = (bankState[2*i +: 2] == BANK_READ);
  end

  logic wrAny, rdAny, wrCycle, rdCycle;
  assign wrAny   = |bankWr;
  assign rdAny   = |bankRd;
  assign wrCycle = clkEn & wrAny;
  assign rdCycle = clkEn & rdAny;

  assign laneCtrl.advance = clkEn;
  assign laneCtrl.wrCycle = wrCycle;
  assign laneCtrl.rdCycle = rdCycle;

  logic wrTailActive, rdTailActive;

  sdram_bytemask_tail #(.TAIL(WR_TAIL)) u_wrTail (
    .clk(clk), .rst(rst), .advance(clkEn), .load(wrCycle), .active(wrTailActive)
  );

  sdram_bytemask_tail #(.TAIL(RD_TAIL)) u_rdTail (
    .clk(clk), .rst(rst), .advance(clkEn), .load(rdCycle), .active(rdTailActive)
  );

  assign accessBusy = wrAny | rdAny | wrTailActive | rdTailActive;

  // Request on the cycle right after the last write data-in cycle
  logic lastWasWrite;
  logic violNow;

  assign violNow = lastWasWrite & ~wrCycle & (sleepReq | holdReq);

  always_ff @(posedge clk) begin
    if (rst) begin
      lastWasWrite <= 1'b0;
      protoViol    <= 1'b0;
    end else begin
      lastWasWrite <= wrCycle;
      protoViol    <= violNow;
    end
  end
endmodule

// File: rtl/sdram_bytemask_datapath.sv
module sdram_bytemask_datapath
  import sdram_bytemask_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int READ_LAT = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  laneCtrl_t             laneCtrl,
  input  logic [DATA_W/8-1:0]   maskIn,
  input  logic [DATA_W-1:0]     wrDataIn,
  input  logic [DATA_W-1:0]     arrRdData,
  output logic [DATA_W/8-1:0]   arrWrStrobe,
  output logic [DATA_W-1:0]     arrWrData,
  output logic [DATA_W-1:0]     rdDataOut,
  output logic [DATA_W/8-1:0]   rdOutEn
);
  localparam int NUM_BYTES = DATA_W / 8;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    logic              laneStrobe;
    logic              laneEnNext;
    logic [READ_LAT-1:0] enPipe;

    // Write side acts in the same cycle
    assign laneStrobe       = laneCtrl.wrCycle & ~maskIn[b];
    assign arrWrStrobe[b]   = laneStrobe;
    assign arrWrData[8*b +: 8] = laneStrobe ? wrDataIn[8*b +: 8] : 8'h00;

    // Read side: enable travels READ_LAT enabled cycles, reset to masked
    assign laneEnNext = laneCtrl.rdCycle & ~maskIn[b];

    always_ff @(posedge clk) begin
      if (rst)
        enPipe <= '0;
      else if (laneCtrl.advance)
        enPipe <= READ_LAT'({enPipe, laneEnNext});
    end

    assign rdOutEn[b]          = enPipe[READ_LAT-1];
    assign rdDataOut[8*b +: 8] = enPipe[READ_LAT-1] ? arrRdData[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/sdram_bytemask_dp.sv
module sdram_bytemask_dp
  import sdram_bytemask_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_BANKS = 2,
  parameter int READ_LAT  = 2,
  parameter int WR_TAIL   = 1,
  parameter int RD_TAIL   = READ_LAT
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clkEn,
  input  logic [2*NUM_BANKS-1:0] bankState,
  input  logic [DATA_W/8-1:0]    maskIn,
  input  logic                   sleepReq,
  input  logic                   holdReq,
  input  logic [DATA_W-1:0]      wrDataIn,
  input  logic [DATA_W-1:0]      arrRdData,
  output logic [DATA_W/8-1:0]    arrWrStrobe,
  output logic [DATA_W-1:0]      arrWrData,
  output logic [DATA_W-1:0]      rdDataOut,
  output logic [DATA_W/8-1:0]    rdOutEn,
  output logic                   accessBusy,
  output logic                   protoViol
);
  laneCtrl_t laneCtrl;

  sdram_bytemask_ctrl #(
    .NUM_BANKS(NUM_BANKS), .WR_TAIL(WR_TAIL), .RD_TAIL(RD_TAIL)
  ) u_ctrl (
    .clk(clk), .rst(rst), .clkEn(clkEn), .bankState(bankState),
    .sleepReq(sleepReq), .holdReq(holdReq), .laneCtrl(laneCtrl),
    .accessBusy(accessBusy), .protoViol(protoViol)
  );

  sdram_bytemask_datapath #(
    .DATA_W(DATA_W), .READ_LAT(READ_LAT)
  ) u_dpath (
    .clk(clk), .rst(rst), .laneCtrl(laneCtrl), .maskIn(maskIn),
    .wrDataIn(wrDataIn), .arrRdData(arrRdData), .arrWrStrobe(arrWrStrobe),
    .arrWrData(arrWrData), .rdDataOut(rdDataOut), .rdOutEn(rdOutEn)
  );
endmodule

// File: rtl/sdram_bytemask_chk.sv
module sdram_bytemask_chk #(
  parameter int NUM_BANKS = 2,
  parameter int NUM_BYTES = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   clkEn,
  input logic [2*NUM_BANKS-1:0] bankState,
  input logic [NUM_BYTES-1:0]   maskIn,
  input logic [NUM_BYTES-1:0]   arrWrStrobe,
  input logic [NUM_BYTES-1:0]   rdOutEn,
  input logic                   accessBusy,
  input logic                   protoViol
);
  logic wrSeen, rdSeen;

  always_comb begin
    wrSeen = 1'b0;
    rdSeen = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (bankState[2*i +: 2] == 2'b10) wrSeen = 1'b1;
      if (bankState[2*i +: 2] == 2'b11) rdSeen = 1'b1;
    end
  end

  AST_WR_MASK_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (clkEn && wrSeen) |-> (arrWrStrobe == ~maskIn)); // R2
  AST_NO_WR_WHEN_SUSPENDED: assert property (@(posedge clk) disable iff (rst)
    !clkEn |-> (arrWrStrobe == '0)); // R5
  AST_RD_MASK_TWO_LATER: assert property (@(posedge clk) disable iff (rst)
    (clkEn && rdSeen) ##1 clkEn |=> (rdOutEn == ~$past(maskIn, 2))); // R3
  AST_NO_RD_OUTPUT_OFF: assert property (@(posedge clk) disable iff (rst)
    (clkEn && !rdSeen) ##1 clkEn |=> (rdOutEn == '0)); // R4
  AST_SUSPEND_HOLDS_EN: assert property (@(posedge clk) disable iff (rst)
    !clkEn |=> $stable(rdOutEn)); // R5
  AST_WR_TAIL_BUSY: assert property (@(posedge clk) disable iff (rst)
    (clkEn && wrSeen) |=> accessBusy); // R6
  AST_RD_TAIL_BUSY: assert property (@(posedge clk) disable iff (rst)
    (clkEn && rdSeen) ##1 clkEn |=> accessBusy); // R6
  AST_VIOL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    protoViol |=> !protoViol); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (rdOutEn == '0 && !protoViol)); // R8
endmodule

bind sdram_bytemask_dp sdram_bytemask_chk #(
  .NUM_BANKS(NUM_BANKS), .NUM_BYTES(DATA_W/8)
) u_chk (
  .clk(clk), .rst(rst), .clkEn(clkEn), .bankState(bankState), .maskIn(maskIn),
  .arrWrStrobe(arrWrStrobe), .rdOutEn(rdOutEn), .accessBusy(accessBusy),
  .protoViol(protoViol)
);

// File: tb/sim_sdram_bytemask_dp.sv
module sim_sdram_bytemask_dp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clkEn = 1'b0;
  logic [3:0]  bankState = 4'b0000;
  logic [1:0]  maskIn = 2'b00;
  logic        sleepReq = 1'b0;
  logic        holdReq = 1'b0;
  logic [15:0] wrDataIn = 16'h0000;
  logic [15:0] arrRdData = 16'h0000;
  logic [1:0]  arrWrStrobe;
  logic [15:0] arrWrData;
  logic [15:0] rdDataOut;
  logic [1:0]  rdOutEn;
  logic        accessBusy;
  logic        protoViol;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  sdram_bytemask_dp u0 (
    .clk(clk), .rst(rst), .clkEn(clkEn), .bankState(bankState), .maskIn(maskIn),
    .sleepReq(sleepReq), .holdReq(holdReq), .wrDataIn(wrDataIn),
    .arrRdData(arrRdData), .arrWrStrobe(arrWrStrobe), .arrWrData(arrWrData),
    .rdDataOut(rdDataOut), .rdOutEn(rdOutEn), .accessBusy(accessBusy),
    .protoViol(protoViol)
  );

  // Expected state derived from the requirements
  logic [1:0] expEn1 = 2'b00, expEn2 = 2'b00;
  int         expWrTail = 0, expRdTail = 0;
  logic       expLastWr = 1'b0, expViol = 1'b0;

  function automatic logic anyCode(logic [3:0] bs, logic [1:0] code);
    return (bs[1:0] == code) || (bs[3:2] == code);
  endfunction

  always @(posedge clk) begin
    logic wrc, rdc;
    wrc = clkEn && anyCode(bankState, 2'b10);
    rdc = clkEn && anyCode(bankState, 2'b11);
    if (rst) begin
      expEn1 <= 2'b00; expEn2 <= 2'b00; expWrTail <= 0; expRdTail <= 0;
      expLastWr <= 1'b0; expViol <= 1'b0;
    end else begin
      expLastWr <= wrc;
      expViol   <= expLastWr && !wrc && (sleepReq || holdReq);
      if (clkEn) begin
        expEn1    <= rdc ? ~maskIn : 2'b00;
        expEn2    <= expEn1;
        expWrTail <= wrc ? 1 : (expWrTail > 0 ? expWrTail - 1 : 0);
        expRdTail <= rdc ? 2 : (expRdTail > 0 ? expRdTail - 1 : 0);
      end
    end
  end

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] byteGate(logic [1:0] en, logic [15:0] d);
    return {en[1] ? d[15:8] : 8'h00, en[0] ? d[7:0] : 8'h00};
  endfunction

  // Drive one cycle at the falling edge, then check all outputs
  task automatic cyc(logic [3:0] bs, logic [1:0] m, logic ce, logic sl, logic hd,
                     string rdTag);
    logic [1:0] expStb;
    logic       expBusy;
    @(negedge clk);
    bankState = bs; maskIn = m; clkEn = ce; sleepReq = sl; holdReq = hd;
    wrDataIn = 16'($urandom); arrRdData = 16'($urandom);
    #1;
    expStb  = (ce && anyCode(bs, 2'b10)) ? ~m : 2'b00;
    expBusy = anyCode(bs, 2'b10) || anyCode(bs, 2'b11) || expWrTail != 0 || expRdTail != 0;
    check(ce ? "R2" : "R5", "arrWrStrobe", {14'd0, arrWrStrobe}, {14'd0, expStb});
    check("R2", "arrWrData", arrWrData, byteGate(expStb, wrDataIn));
    check(rdTag, "rdOutEn", {14'd0, rdOutEn}, {14'd0, expEn2});
    check(rdTag, "rdDataOut", rdDataOut, byteGate(expEn2, arrRdData));
    check("R6", "accessBusy", {15'd0, accessBusy}, {15'd0, expBusy});
    check("R7", "protoViol", {15'd0, protoViol}, {15'd0, expViol});
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R8: reset state
    check("R8", "rdOutEn", {14'd0, rdOutEn}, 16'h0000);
    check("R8", "accessBusy", {15'd0, accessBusy}, 16'h0000);
    check("R8", "protoViol", {15'd0, protoViol}, 16'h0000);

    // R1: lanes independent on write
    cyc(4'b0010, 2'b01, 1'b1, 1'b0, 1'b0, "R3");
    check("R1", "lane strobes", {14'd0, arrWrStrobe}, 16'h0002);
    check("R1", "lane data", {8'h00, arrWrData[7:0]}, 16'h0000);
    cyc(4'b0000, 2'b00, 1'b1, 1'b0, 1'b0, "R3");
    cyc(4'b0000, 2'b00, 1'b1, 1'b0, 1'b0, "R3");

    // R3/R1: read with mask 10, observe two cycles later
    cyc(4'b1100, 2'b10, 1'b1, 1'b0, 1'b0, "R3");
    cyc(4'b0100, 2'b11, 1'b1, 1'b0, 1'b0, "R3");
    cyc(4'b0100, 2'b11, 1'b1, 1'b0, 1'b0, "R3");
    check("R1", "read lane enable", {14'd0, rdOutEn}, 16'h0001);

    // R4: no read while mask low
    cyc(4'b0101, 2'b00, 1'b1, 1'b0, 1'b0, "R4");
    cyc(4'b0001, 2'b00, 1'b1, 1'b0, 1'b0, "R4");
    cyc(4'b0000, 2'b00, 1'b1, 1'b0, 1'b0, "R4");
    check("R4", "no-read enables", {14'd0, rdOutEn}, 16'h0000);

    // R5: suspend inside a read pipeline
    cyc(4'b0011, 2'b00, 1'b1, 1'b0, 1'b0, "R5");
    for (int k = 0; k < 3; k++) cyc(4'b0011, 2'b11, 1'b0, 1'b0, 1'b0, "R5");
    cyc(4'b0000, 2'b11, 1'b1, 1'b0, 1'b0, "R5");
    cyc(4'b0000, 2'b11, 1'b1, 1'b0, 1'b0, "R5");
    check("R5", "enable after suspend", {14'd0, rdOutEn}, 16'h0003);
    cyc(4'b0000, 2'b00, 1'b1, 1'b0, 1'b0, "R5");

    // R6/R7: request right after last write
    cyc(4'b1000, 2'b00, 1'b1, 1'b0, 1'b0, "R3");
    cyc(4'b0000, 2'b00, 1'b1, 1'b1, 1'b0, "R3");
    check("R6", "write tail busy", {15'd0, accessBusy}, 16'h0001);
    cyc(4'b0000, 2'b00, 1'b1, 1'b0, 1'b0, "R3");
    check("R7", "violation flag", {15'd0, protoViol}, 16'h0001);
    check("R6", "write tail done", {15'd0, accessBusy}, 16'h0000);
    cyc(4'b0000, 2'b00, 1'b1, 1'b0, 1'b1, "R3");
    check("R7", "violation clears", {15'd0, protoViol}, 16'h0000);

    // Exhaustive sweep of bank codes, mask and clock enable
    for (int bs = 0; bs < 16; bs++)
      for (int m = 0; m < 4; m++)
        for (int ce = 0; ce < 2; ce++)
          cyc(4'(bs), 2'(m), 1'(ce), 1'($urandom), 1'($urandom), ce != 0 ? "R3" : "R5");

    // Random run
    for (int k = 0; k < 600; k++) begin
      logic ce;
      ce = ($urandom % 4) != 0;
      cyc(4'($urandom), 2'($urandom), ce, 1'($urandom), 1'($urandom), ce ? "R3" : "R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule